// File: doc/BRIEF.md
# Configurable SPI Master Controller

This block is a single-word SPI master that hangs off a simple register bus. Software writes the control and divider registers, then writes a byte to the data register while the block is idle. That write starts a transfer: eight bits go out on MOSI, eight bits are taken in from MISO, and SCK is derived from the system clock through a programmable even divider. When the transfer ends, a status flag is raised and the received byte can be read from the data register. The read also clears the flag.

Control fields select the SCK resting level, the sampling phase, the bit order on the wire, automatic slave-select generation and a clock freeze during system wait mode. The bit order changes only the serialisation. The register image always keeps the most significant bit in bit 7. Polarity, phase, bit order and the wait-freeze bit are captured when a transfer starts. The slave-select enable and the pin direction input are applied live.

Top module: `spi_master_ctl`

## Requirements
- R1: SCK rests at the polarity bit (control register, address 0, bit 0) whenever no transfer is in progress, both before a transfer starts and after it ends.
- R2: With the phase bit (address 0, bit 1) at 0, the first bit is on MOSI before the first SCK edge, MISO is sampled on leading edges and MOSI changes on trailing edges. With the phase bit at 1, MOSI changes on leading edges and MISO is sampled on trailing edges.
- R3: Bit-order bit (address 0, bit 2) at 0 puts the MSB on the wire first, and at 1 puts the LSB first. In both cases the written byte and the received byte read from address 2 have their MSB in bit 7.
- R4: The block drives slave select (ss_oe_o=1) only when the auto-select bit (address 0, bit 3) and ss_dir_i are both 1. Otherwise ss_oe_o=0 and ss_o stays 1 throughout the transfer.
- R5: When slave select is driven, ss_o falls one half SCK period before the first SCK edge and rises one half SCK period after the sixteenth edge.
- R6: With the wait-freeze bit (address 0, bit 4) at 1, asserting wait_i stops SCK and all transfer progress. The transfer resumes from the same bit when wait_i drops. With the bit at 0, the transfer keeps running under wait_i.
- R7: The divider register (address 1, 7-bit value d) sets an SCK period of 2*(d+1) system clocks. Each transfer has exactly 16 SCK edges.
- R8: A write to the data register (address 2) while idle starts a transfer. A write to it during a transfer is ignored and does not alter the bits being sent.
- R9: Status (address 3) bit 0 is set when a transfer completes and is cleared by a read strobe on address 2. Status bit 1 reads 1 while a transfer is in progress.
- R10: After reset, the control, divider, data and status registers read 0, SCK is low, ss_o is 1 and ss_oe_o is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe (side effects only) |
| addr_i | input | 2 | Register address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for addr_i |
| wait_i | input | 1 | System wait-mode indication |
| ss_dir_i | input | 1 | Slave-select pin configured as output |
| sck_o | output | 1 | Serial clock |
| mosi_o | output | 1 | Serial data out |
| miso_i | input | 1 | Serial data in |
| ss_o | output | 1 | Slave select, active low |
| ss_oe_o | output | 1 | Slave-select output enable |

## Verification
The inline assertions check several rules on every cycle: the SCK phase returns to rest between transfers, the divider count stays inside its limit, the step counter stays bounded, SCK does not move in the cycle a transfer starts, SCK holds still while frozen by wait mode, and the completion flag rises only as the transfer ends. The following can be shown only by the bench's scenarios, which play a bit-level slave against the block: the wire bit order under every polarity, phase and order combination, the exact half-period gaps around slave select, the SCK period for several divider values, the received byte image, resumption after a wait freeze, and the rejection of writes during a transfer.

// File: rtl/spi_mst_pkg.sv
package spi_mst_pkg;
  localparam int unsigned WORD_W = 8;

  typedef struct packed {
    logic halt_wait;
    logic ss_auto;
    logic lsb_first;
    logic cpha;
    logic cpol;
  } spi_cfg_t;

  localparam int unsigned CFG_W = $bits(spi_cfg_t);

  localparam logic [1:0] ADDR_CFG  = 2'd0;
  localparam logic [1:0] ADDR_DIV  = 2'd1;
  localparam logic [1:0] ADDR_DATA = 2'd2;
  localparam logic [1:0] ADDR_STAT = 2'd3;

  function automatic logic [WORD_W-1:0] bit_rev(input logic [WORD_W-1:0] v);
    for (int i = 0; i < WORD_W; i++) bit_rev[i] = v[WORD_W-1-i];
  endfunction
endpackage

// File: rtl/spi_half_div.sv
module spi_half_div #(
  parameter int unsigned DIV_W = 7
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             en_i,
  input  logic [DIV_W-1:0] half_m1_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] cnt_q;

  assign tick_o = en_i && (cnt_q == half_m1_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (clr_i)   cnt_q <= '0;
    else if (en_i)    cnt_q <= tick_o ? '0 : cnt_q + 1'b1;
  end

  // R7
  cnt_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i |-> cnt_q <= half_m1_i);
endmodule

// File: rtl/spi_shift_eng.sv
module spi_shift_eng #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         start_i,
  input  logic [W-1:0] tx_i,
  input  logic         cpha_i,
  input  logic         tick_i,
  input  logic         miso_i,
  output logic         busy_o,
  output logic         done_o,
  output logic [W-1:0] rx_o,
  output logic         ph_o,
  output logic         mosi_o
);
  localparam int unsigned STEPS  = 2 * W + 1;
  localparam int unsigned STEP_W = $clog2(STEPS + 1);

  logic              busy_q, ph_q, mosi_q;
  logic [STEP_W-1:0] step_q, nxt;
  logic [W-1:0]      sreg_q, rx_q;
  logic              is_edge, lead, do_shift, do_sample;

  assign nxt       = step_q + 1'b1;
  assign is_edge   = busy_q && tick_i && (nxt <= STEP_W'(2 * W));
  assign lead      = nxt[0];
  assign do_shift  = is_edge && (cpha_i ? lead : !lead);
  assign do_sample = is_edge && (cpha_i ? !lead : lead);
  assign done_o    = busy_q && tick_i && (nxt == STEP_W'(STEPS));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      step_q <= '0;
      ph_q   <= 1'b0;
      mosi_q <= 1'b0;
      sreg_q <= '0;
      rx_q   <= '0;
    end else if (start_i && !busy_q) begin
      busy_q <= 1'b1;
      step_q <= '0;
      ph_q   <= 1'b0;
      sreg_q <= tx_i;
      mosi_q <= tx_i[W-1];
      rx_q   <= '0;
    end else if (busy_q && tick_i) begin
      step_q <= nxt;
      if (is_edge) ph_q <= ~ph_q;
      if (do_shift) begin
        mosi_q <= sreg_q[W-1];
        sreg_q <= {sreg_q[W-2:0], 1'b0};
      end
      if (do_sample) rx_q <= {rx_q[W-2:0], miso_i};
      if (done_o) begin
        busy_q <= 1'b0;
        step_q <= '0;
      end
    end
  end

  assign busy_o = busy_q;
  assign rx_o   = rx_q;
  assign ph_o   = ph_q;
  assign mosi_o = cpha_i ? mosi_q : sreg_q[W-1];

  // R1
  ph_rest_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_q |-> !ph_q);
  // R7
  step_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |-> step_q < STEP_W'(STEPS));
endmodule

// File: rtl/spi_master_ctl.sv
module spi_master_ctl
  import spi_mst_pkg::*;
#(
  parameter int unsigned DIV_W = 7
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [1:0]        addr_i,
  input  logic [WORD_W-1:0] wdata_i,
  output logic [WORD_W-1:0] rdata_o,
  input  logic              wait_i,
  input  logic              ss_dir_i,
  output logic              sck_o,
  output logic              mosi_o,
  input  logic              miso_i,
  output logic              ss_o,
  output logic              ss_oe_o
);
  spi_cfg_t          cfg_q;
  logic [DIV_W-1:0]  div_q, act_div_q;
  logic [WORD_W-1:0] data_q, rx_w, tx_w;
  logic              done_q;
  logic              act_cpol_q, act_cpha_q, act_lsb_q, act_halt_q;
  logic              busy_w, done_w, ph_w, tick_w, run_w, start_w, ss_drive;

  assign start_w  = wr_en_i && (addr_i == ADDR_DATA) && !busy_w;
  assign tx_w     = cfg_q.lsb_first ? bit_rev(wdata_i) : wdata_i;
  assign run_w    = busy_w && !(act_halt_q && wait_i);
  assign ss_drive = cfg_q.ss_auto && ss_dir_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q      <= '0;
      div_q      <= '0;
      act_div_q  <= '0;
      act_cpol_q <= 1'b0;
      act_cpha_q <= 1'b0;
      act_lsb_q  <= 1'b0;
      act_halt_q <= 1'b0;
      data_q     <= '0;
      done_q     <= 1'b0;
    end else begin
      if (wr_en_i && addr_i == ADDR_CFG) cfg_q <= spi_cfg_t'(wdata_i[CFG_W-1:0]);
      if (wr_en_i && addr_i == ADDR_DIV) div_q <= wdata_i[DIV_W-1:0];
      if (start_w) begin
        act_div_q  <= div_q;
        act_cpol_q <= cfg_q.cpol;
        act_cpha_q <= cfg_q.cpha;
        act_lsb_q  <= cfg_q.lsb_first;
        act_halt_q <= cfg_q.halt_wait;
      end
      if (done_w) begin
        data_q <= act_lsb_q ? bit_rev(rx_w) : rx_w;
        done_q <= 1'b1;
      end else if (rd_en_i && addr_i == ADDR_DATA) begin
        done_q <= 1'b0;
      end
    end
  end

  spi_half_div #(.DIV_W(DIV_W)) u_div (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (start_w),
    .en_i      (run_w),
    .half_m1_i (act_div_q),
    .tick_o    (tick_w)
  );

  spi_shift_eng #(.W(WORD_W)) u_eng (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start_w),
    .tx_i    (tx_w),
    .cpha_i  (act_cpha_q),
    .tick_i  (tick_w),
    .miso_i  (miso_i),
    .busy_o  (busy_w),
    .done_o  (done_w),
    .rx_o    (rx_w),
    .ph_o    (ph_w),
    .mosi_o  (mosi_o)
  );

  assign sck_o   = busy_w ? (act_cpol_q ^ ph_w) : cfg_q.cpol;
  assign ss_o    = ss_drive ? !busy_w : 1'b1;
  assign ss_oe_o = ss_drive;

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      ADDR_CFG:  rdata_o[CFG_W-1:0] = cfg_q;
      ADDR_DIV:  rdata_o[DIV_W-1:0] = div_q;
      ADDR_DATA: rdata_o            = data_q;
      default:   rdata_o[1:0]       = {busy_w, done_q};
    endcase
  end

  // R5
  lead_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_w) |-> $stable(sck_o));
  // R6
  wait_freeze_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_w && act_halt_q && wait_i) |=> $stable(sck_o));
  // R9
  done_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_q) |-> $fell(busy_w));
endmodule

// File: tb/spi_master_ctl_tb.sv
module spi_master_ctl_tb;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0, rst_ni = 1'b0;
  logic       wr_en = 1'b0, rd_en = 1'b0, wait_in = 1'b0, ss_dir = 1'b1;
  logic [1:0] addr = '0;
  logic [7:0] wdata = '0, rdata;
  logic       sck, mosi, miso, ss, ss_oe;

  int errors = 0, checks = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_master_ctl u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .wr_en_i(wr_en), .rd_en_i(rd_en),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .wait_i(wait_in),
    .ss_dir_i(ss_dir), .sck_o(sck), .mosi_o(mosi), .miso_i(miso),
    .ss_o(ss), .ss_oe_o(ss_oe)
  );

  function automatic logic [7:0] rev8(input logic [7:0] v);
    for (int i = 0; i < 8; i++) rev8[i] = v[7-i];
  endfunction

  // bit-level slave and timing monitor
  logic [7:0] wire_s = '0, cap = '0;
  logic       m_cpha = 1'b0, prev_sck = 1'b0, prev_ss = 1'b1;
  int arm_req = 0, arm_ack = 0, sidx = 0, edges = 0, cyc = 0;
  int t_fall = 0, t_rise = 0, t_first = 0, t_last = 0;

  initial miso = 1'b0;

  always @(negedge clk) begin
    cyc++;
    if (arm_req != arm_ack) begin
      arm_ack = arm_req;
      edges = 0; cap = '0; t_fall = 0; t_rise = 0; t_first = 0; t_last = 0;
      if (!m_cpha) begin miso = wire_s[7]; sidx = 1; end
      else sidx = 0;
    end
    if (prev_ss && !ss) t_fall = cyc;
    if (!prev_ss && ss) t_rise = cyc;
    if (sck !== prev_sck) begin
      edges++;
      if (edges == 1) t_first = cyc;
      t_last = cyc;
      if (edges % 2 == 1) begin
        if (!m_cpha) cap = {cap[6:0], mosi};
        else if (sidx < 8) begin miso = wire_s[7-sidx]; sidx++; end
      end else begin
        if (m_cpha) cap = {cap[6:0], mosi};
        else if (sidx < 8) begin miso = wire_s[7-sidx]; sidx++; end
      end
    end
    prev_sck = sck;
    prev_ss  = ss;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic bus_rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    addr = a; #1 d = rdata;
  endtask

  // wmode: 0 none, 1 freeze enabled + wait pulse, 2 freeze disabled + wait pulse
  task automatic run_xfer(input bit cpol, input bit cpha, input bit lsb, input bit ss_auto,
                          input int div, input logic [7:0] tx, input logic [7:0] sb,
                          input int wmode, input bit busy_wr);
    logic [7:0] d;
    int t, e0;
    logic s0;
    bus_wr(2'd0, {3'b000, (wmode == 1), ss_auto, lsb, cpha, cpol});
    bus_wr(2'd1, 8'(div));
    wire_s = lsb ? rev8(sb) : sb;
    m_cpha = cpha;
    arm_req++;
    @(negedge clk);
    check(sck == cpol, "R1 idle before", sck, cpol);
    bus_wr(2'd2, tx);
    bus_rd(2'd3, d);
    check(d[1] == 1'b1, "R9 busy bit", d, 2);
    if (busy_wr) begin
      repeat (6) @(negedge clk);
      bus_wr(2'd2, ~tx);
    end
    if (wmode != 0) begin
      repeat (10) @(negedge clk);
      wait_in = 1'b1;
      @(negedge clk);
      e0 = edges; s0 = sck;
      repeat (20) @(negedge clk);
      if (wmode == 1) begin
        check(edges == e0 && sck == s0, "R6 frozen", edges, e0);
      end else begin
        check(edges > e0, "R6 runs", edges, e0 + 1);
      end
      wait_in = 1'b0;
    end
    t = 0;
    d = '0;
    while (!d[0] && t < 5000) begin bus_rd(2'd3, d); t++; end
    @(negedge clk);
    check(d[0] == 1'b1, "R9 done set", d, 1);
    check(sck == cpol, "R1 idle after", sck, cpol);
    check(cap == (lsb ? rev8(tx) : tx), "R2 R3 R8 wire data", cap, lsb ? rev8(tx) : tx);
    check(edges == 16, "R7 edge count", edges, 16);
    if (wmode != 1 && !busy_wr) begin
      check(t_last - t_first == 15 * (div + 1), "R7 period", t_last - t_first, 15 * (div + 1));
    end
    if (ss_auto && ss_dir) begin
      check(t_first - t_fall == div + 1, "R5 lead", t_first - t_fall, div + 1);
      check(t_rise - t_last == div + 1, "R5 trail", t_rise - t_last, div + 1);
    end else begin
      check(t_fall == 0 && ss_oe == 1'b0, "R4 ss not driven", t_fall, 0);
    end
    @(negedge clk);
    addr = 2'd2; rd_en = 1'b1; #1 d = rdata;
    check(d == sb, "R3 rx image", d, sb);
    @(negedge clk);
    rd_en = 1'b0;
    bus_rd(2'd3, d);
    check(d[0] == 1'b0, "R9 done cleared", d, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [7:0] d;
    int dv[3] = '{0, 1, 3};
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    // R10
    for (int a = 0; a < 4; a++) begin
      bus_rd(2'(a), d);
      check(d == 8'h00, "R10 reg reset", d, 0);
    end
    check(sck == 1'b0 && ss == 1'b1 && ss_oe == 1'b0, "R10 pins reset", {sck, ss, ss_oe}, 3'b010);

    for (int m = 0; m < 8; m++) begin
      for (int k = 0; k < 3; k++) begin
        run_xfer(m[0], m[1], m[2], 1'b1, dv[k], 8'(8'hA5 ^ (m * 37 + k * 11)),
                 8'(8'h3C ^ (m * 19 + k * 71)), 0, 1'b0);
      end
    end
    // R4: auto-select off, then pin direction off
    run_xfer(1'b0, 1'b0, 1'b0, 1'b0, 1, 8'hC3, 8'h5A, 0, 1'b0);
    ss_dir = 1'b0;
    run_xfer(1'b1, 1'b1, 1'b0, 1'b1, 1, 8'h81, 8'h7E, 0, 1'b0);
    ss_dir = 1'b1;
    // R8: write during transfer
    run_xfer(1'b0, 1'b1, 1'b1, 1'b1, 2, 8'h96, 8'h0F, 0, 1'b1);
    // R6: freeze and no freeze
    run_xfer(1'b1, 1'b0, 1'b0, 1'b1, 1, 8'hE1, 8'h1E, 1, 1'b0);
    run_xfer(1'b0, 1'b1, 1'b1, 1'b1, 1, 8'h4B, 8'hB4, 2, 1'b0);
    // R7: largest divider
    run_xfer(1'b0, 1'b0, 1'b0, 1'b1, 127, 8'h01, 8'h80, 0, 1'b0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule